// File: doc/BRIEF.md
# LUT-based programmable logic cell

This block is the basic configurable cell of an SRAM-configured programmable fabric. Three logic inputs select one of eight stored table bits, so the cell can realise any Boolean function of three variables. A configuration bit chooses whether the storage element sees that table result or a separate direct input. A second bit makes the storage element either a rising-edge flip-flop or a level-sensitive latch that is open while the clock is high. A third bit picks whether the cell output shows the stored value or the unregistered selected data.

All eleven configuration bits sit in one shift register. While the load enable is high, that register shifts in one bit per rising clock edge. The oldest bit appears on a serial output, so several cells can share one configuration chain. A synchronous reset clears the stored data bit but leaves the configuration untouched. Routing, carry logic and arrays of cells are outside this block.

Top module: `lut_logic_cell`

## Requirements
- R1: While cfg_en is high, each rising clock edge shifts cfg_din into configuration bit 0 and moves every bit up one place. The 11-bit word is therefore sent most significant bit first. cfg_dout always shows bit 10. While cfg_en is low, the configuration does not change.
- R2: Configuration bits 7..0 form the table. The LUT result is table bit {in_a,in_b,in_c}, with in_a as the most significant select bit.
- R3: The table value 0xD5 (bits 0..7 = 1,0,1,0,1,0,1,1) makes the LUT result equal (in_a & in_b) | !in_c for all eight input combinations.
- R4: Configuration bit 8 selects the data source. 0 selects the LUT result and 1 selects direct_in.
- R5: Configuration bit 10 selects the output. 1 drives cell_out from the selected data with no clock delay. 0 drives it from the storage element.
- R6: With configuration bit 9 at 0, the storage element is a flip-flop. It captures the selected data on the rising clock edge and holds it at all other times.
- R7: With configuration bit 9 at 1, the storage element is a latch. It follows the selected data while clk is high and holds the last value while clk is low.
- R8: rst high at a rising clock edge clears the stored bit to 0 in both storage modes, whatever the data input. The configuration is not affected by rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the latch enable in latch mode |
| rst | input | 1 | Synchronous active-high clear of the stored bit |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (bit 10) |
| in_a | input | 1 | LUT select, most significant |
| in_b | input | 1 | LUT select, middle |
| in_c | input | 1 | LUT select, least significant |
| direct_in | input | 1 | Direct data input that can bypass the LUT |
| cell_out | output | 1 | Cell output |

## Verification
The LUT is swept over all eight input combinations for six tables. The tables are a constant-one minterm, a constant-top minterm, parity, majority, a mixed pattern and the 0xD5 function. Together these show the select order and rule out a swapped or stuck select line. The same data is then sent through the flip-flop and through the latch. Input changes made during the high phase and during the low phase separate edge capture from transparency. Reset is applied while the data is 1 in both modes. Serial readback and held configuration show that shifting happens only while enabled.

// File: rtl/lut_logic_cell.sv
module lut_logic_cell (
  input  logic clk,
  input  logic rst,
  input  logic cfg_en,
  input  logic cfg_din,
  output logic cfg_dout,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  input  logic direct_in,
  output logic cell_out
);
  localparam int SEL_W   = 3;
  localparam int LUT_BITS = 1 << SEL_W;
  localparam int IN_SEL  = LUT_BITS;
  localparam int MODE    = LUT_BITS + 1;
  localparam int OUT_SEL = LUT_BITS + 2;
  localparam int CFG_W   = LUT_BITS + 3;

  logic [CFG_W-1:0]    cfg_q;
  logic [LUT_BITS-1:0] lut_tbl;
  logic [SEL_W-1:0]    lut_idx;
  logic lut_bit, d_sel, ff_q, lat_q, held;

  always_ff @(posedge clk)
    if (cfg_en) cfg_q <= {cfg_q[CFG_W-2:0], cfg_din};

  assign cfg_dout = cfg_q[CFG_W-1];
  assign lut_tbl  = cfg_q[LUT_BITS-1:0];
  assign lut_idx  = {in_a, in_b, in_c};
  assign lut_bit  = lut_tbl[lut_idx];
  assign d_sel    = cfg_q[IN_SEL] ? direct_in : lut_bit;

  always_ff @(posedge clk)
    ff_q <= rst ? 1'b0 : d_sel;

  always_latch
    if (clk) lat_q <= rst ? 1'b0 : d_sel;

  assign held     = cfg_q[MODE] ? lat_q : ff_q;
  assign cell_out = cfg_q[OUT_SEL] ? d_sel : held;
endmodule

module lut_logic_cell_chk #(
  parameter int CFG_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             cfg_din,
  input logic [CFG_W-1:0] cfg_q,
  input logic             d_sel,
  input logic             cell_out
);
  localparam int MODE    = CFG_W - 2;
  localparam int OUT_SEL = CFG_W - 1;

  AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_q == {$past(cfg_q[CFG_W-2:0]), $past(cfg_din)}); // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_q)); // R1

  AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !cfg_q[MODE] && !cfg_q[OUT_SEL]) |=> cell_out == $past(d_sel)); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (cfg_en)
    (rst && !cfg_q[OUT_SEL]) |=> cell_out == 1'b0); // R8
endmodule

bind lut_logic_cell lut_logic_cell_chk #(.CFG_W(11)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
  .cfg_q(cfg_q), .d_sel(d_sel), .cell_out(cell_out)
);

// File: tb/lut_logic_cell_test.sv
module lut_logic_cell_test;
  logic clk = 1'b0, rst = 1'b1, cfg_en = 1'b0, cfg_din = 1'b0;
  logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0, direct_in = 1'b0;
  logic cfg_dout, cell_out;
  int   n_run = 0, n_fail = 0;
  logic prev;

  lut_logic_cell uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .direct_in(direct_in), .cell_out(cell_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic load(input logic [10:0] w);
    @(negedge clk); #2;
    cfg_en = 1'b1;
    for (int i = 10; i >= 0; i--) begin
      cfg_din = w[i];
      @(negedge clk); #2;
    end
    cfg_en = 1'b0;
  endtask

  task automatic set_in(input int idx);
    {in_a, in_b, in_c} = idx[2:0];
  endtask

  function automatic logic fn_d5(input int idx);
    logic a, b, c;
    a = idx[2]; b = idx[1]; c = idx[0];
    return (a & b) | !c;
  endfunction

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] tbls [6];
    tbls = '{8'hD5, 8'h96, 8'hE8, 8'h01, 8'h80, 8'h3C};

    // R8 reset state in both modes, with table all ones
    load({1'b0, 1'b0, 1'b0, 8'hFF});
    set_in(3);
    @(negedge clk); #2;
    chk("R8 reset ff", cell_out, 1'b0);
    load({1'b0, 1'b1, 1'b0, 8'hFF});
    @(posedge clk); #2;
    chk("R8 reset latch high", cell_out, 1'b0);
    @(negedge clk); #2;
    rst = 1'b0;

    // R1 serial readback and hold
    load(11'b100_1010_0110);
    chk("R1 dout msb", cfg_dout, 1'b1);
    for (int k = 0; k < 4; k++) begin
      cfg_din = k[0];
      @(negedge clk); #2;
    end
    chk("R1 hold dout", cfg_dout, 1'b1);
    set_in(1);
    #1 chk("R1 hold table", cell_out, 1'b1);
    cfg_en = 1'b1; cfg_din = 1'b0;
    @(negedge clk); #2;
    cfg_en = 1'b0;
    chk("R1 shift one", cfg_dout, 1'b0);

    // R2 R3 R5 combinational sweep over several tables
    foreach (tbls[t]) begin
      load({1'b1, 1'b0, 1'b0, tbls[t]});
      for (int idx = 0; idx < 8; idx++) begin
        set_in(idx);
        #1 chk("R2 R5 table bit", cell_out, tbls[t][idx]);
        if (tbls[t] == 8'hD5) chk("R3 function", cell_out, fn_d5(idx));
        #1;
      end
    end

    // R4 direct input bypass
    load({1'b1, 1'b0, 1'b1, 8'hFF});
    for (int k = 0; k < 4; k++) begin
      set_in(k * 2);
      direct_in = k[0];
      #1 chk("R4 direct", cell_out, k[0]);
    end
    direct_in = 1'b0;

    // R6 flip-flop timing
    load({1'b0, 1'b0, 1'b0, 8'hD5});
    @(negedge clk); #2;
    prev = cell_out;
    for (int idx = 0; idx < 8; idx++) begin
      set_in(idx);
      #2 chk("R6 hold low", cell_out, prev);
      @(posedge clk); #2;
      chk("R6 capture", cell_out, fn_d5(idx));
      set_in(idx ^ 7);
      #2 chk("R6 hold high", cell_out, fn_d5(idx));
      prev = fn_d5(idx);
      @(negedge clk); #2;
    end

    // R7 latch timing
    load({1'b0, 1'b1, 1'b0, 8'hD5});
    @(posedge clk); #2;
    prev = cell_out;
    @(negedge clk); #2;
    for (int idx = 0; idx < 8; idx++) begin
      set_in(idx);
      #2 chk("R7 hold low", cell_out, prev);
      @(posedge clk); #2;
      chk("R7 open", cell_out, fn_d5(idx));
      set_in(idx ^ 7);
      #2 chk("R7 transparent", cell_out, fn_d5(idx ^ 7));
      prev = fn_d5(idx ^ 7);
      @(negedge clk); #2;
    end

    // R8 reset with data 1, config kept
    load({1'b0, 1'b0, 1'b1, 8'h00});
    direct_in = 1'b1;
    @(negedge clk); #2;
    chk("R8 pre ff", cell_out, 1'b1);
    rst = 1'b1;
    @(negedge clk); #2;
    chk("R8 clear ff", cell_out, 1'b0);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R8 config kept", cell_out, 1'b1);
    load({1'b0, 1'b1, 1'b1, 8'h00});
    rst = 1'b1;
    @(posedge clk); #2;
    chk("R8 clear latch", cell_out, 1'b0);
    @(negedge clk); #2;
    rst = 1'b0;
    #2 chk("R8 latch holds zero", cell_out, 1'b0);
    @(posedge clk); #2;
    chk("R8 latch reopens", cell_out, 1'b1);
    chk("R8 dout kept", cfg_dout, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule